// File: doc/BRIEF.md
# CSR Register Bank

This block is a bank of configuration and status registers that sits on a narrow slave bus used by software. The bus moves 8-bit words. Its address holds a 5-bit bank select, which can pick one of up to 32 banks, and a register word offset. The bank answers only when the select bits match its own bank number. Every cycle, the read port returns the word addressed in the previous cycle. A write takes effect when the write enable is high.

The bank holds a fixed map. Offset 0 is a raw register: the core sees the written value together with a one-cycle valid pulse, and the core itself supplies what a read returns. The other registers are managed fields. Each field has one access policy for the bus and another for the core. A field wider than 8 bits takes consecutive offsets, and the most significant word sits at the lowest offset. The field kinds are:

- **Configuration field:** the bus can read and write it, and the core only reads it.
- **Shared field:** both the bus and the core can write it. When both write in the same cycle, the core wins.
- **Live status field:** the core drives it continuously and has no strobe. The bus only reads it.
- **Event field:** the core loads it through a strobe, and the bus can only read it.
- **Command field:** the bus can only write it, and the core reads it.

Top module: `csrb_top`

## Requirements
- R1: The bank responds only when `busAdr[13:9]` equals `BANK_SEL` (default 3). Any other select value leaves all state unchanged and makes the read word 0.
- R2: `busDatR` is a register. In the cycle after address A is presented, it shows the word at A, taken from the state before any write in that same cycle.
- R3: A write to offset 0 loads `busDatW[RAW_W-1:0]` into `rawVal` and sets `rawStb` high for exactly the following cycle. A read of offset 0 returns `rawRd`, zero-extended.
- R4: Wide fields are sliced MSB-first. With the default widths the layout is as follows:
  - the 16-bit configuration field is bits 15:8 at offset 1 and bits 7:0 at offset 2;
  - the 12-bit shared field is bits 11:8 (in the word's low bits, upper bits 0) at offset 3 and bits 7:0 at offset 4;
  - the 10-bit live field is bits 9:8 at offset 5 and bits 7:0 at offset 6.
- R5: A bus write to one word of the configuration field changes only that byte. The new value appears on `cfgQ` one cycle after the write, and `cfgQ` holds its value while no write arrives.
- R6: When `shrStb` is high, the whole shared field loads `shrIn`, even if the bus writes a word of that field in the same cycle. Without the strobe, bus writes update the addressed byte. `shrQ` shows the stored value.
- R7: A read of the live field (offsets 5 and 6) returns `liveIn` as it was in the addressed cycle. Bus writes there have no effect.
- R8: The event field (offset 7) loads `cntIn` when `cntStb` is high and ignores bus writes. The bus reads it, and `cntQ` shows it.
- R9: A bus write to the command field (offset 8) updates `cmdQ`. A bus read of that offset returns 0.
- R10: Offsets 9 and above read as 0, and writes to them change nothing.
- R11: After reset, `busDatR`, `rawVal`, `rawStb`, `cfgQ`, `shrQ`, `cntQ` and `cmdQ` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAdr | input | 14 | Bank select (13:9) and word offset (8:0) |
| busWe | input | 1 | Bus write enable |
| busDatW | input | 8 | Bus write data |
| busDatR | output | 8 | Registered bus read data |
| rawVal | output | 6 | Last raw register value written by the bus |
| rawStb | output | 1 | One-cycle valid pulse for rawVal |
| rawRd | input | 6 | Core-supplied read value of the raw register |
| cfgQ | output | 16 | Configuration field value seen by the core |
| shrQ | output | 12 | Shared field value seen by the core |
| shrIn | input | 12 | Core write value for the shared field |
| shrStb | input | 1 | Core write strobe for the shared field |
| liveIn | input | 10 | Live status value driven by the core |
| cntQ | output | 8 | Event field value seen by the core |
| cntIn | input | 8 | Core write value for the event field |
| cntStb | input | 1 | Core write strobe for the event field |
| cmdQ | output | 8 | Command field value seen by the core |

## Verification
Two functions can fall in the same cycle:

- a bus write to a shared-field word, and
- a core strobe on that same field.

Directed steps put a bus write to offset 3 or 4 in the same cycle as `shrStb`. Random steps also raise `shrStb` independently of random writes, so the two collide often. The bench model resolves each collision with the core value over the whole field, and `shrQ` and later bus reads are compared against that model every cycle.

// File: rtl/csrb_pkg.sv
package csrb_pkg;
  localparam int WORD_W   = 8;
  localparam int MAX_REGS = 32;

  typedef enum logic [1:0] {
    ACC_RO = 2'd0,
    ACC_WO = 2'd1,
    ACC_RW = 2'd2
  } access_e;

  typedef struct packed {
    logic                hit;
    logic [MAX_REGS-1:0] wrSel;
    logic [MAX_REGS-1:0] rdSel;
  } strobe_t;

  function automatic int wordsFor(input int bits);
    return (bits + WORD_W - 1) / WORD_W;
  endfunction
endpackage

// File: rtl/csrb_ctrl.sv
module csrb_ctrl
  import csrb_pkg::*;
#(
  parameter int ADR_W    = 14,
  parameter int SEL_W    = 5,
  parameter int BANK_SEL = 3,
  parameter int NREG     = 9
) (
  input  logic [ADR_W-1:0] busAdr,
  input  logic             busWe,
  output strobe_t          stb
);
  localparam int OFF_W = ADR_W - SEL_W;

  logic [SEL_W-1:0] selField;
  logic [OFF_W-1:0] offField;

  assign {selField, offField} = busAdr;

  always_comb begin
    stb     = '0;
    stb.hit = (selField == SEL_W'(BANK_SEL));
    for (int i = 0; i < NREG; i++) begin
      if (stb.hit && (offField == OFF_W'(i))) begin
        stb.rdSel[i] = 1'b1;
        stb.wrSel[i] = busWe;
      end
    end
  end
endmodule

// File: rtl/csrb_field.sv
module csrb_field
  import csrb_pkg::*;
#(
  parameter int      W       = 16,
  parameter access_e BUS_ACC = ACC_RW,
  parameter access_e DEV_ACC = ACC_RO,
  localparam int     NW      = (W + WORD_W - 1) / WORD_W,
  localparam int     PW      = NW * WORD_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NW-1:0]     busWr,
  input  logic [WORD_W-1:0] busDat,
  input  logic [W-1:0]      devIn,
  input  logic              devStb,
  output logic [W-1:0]      devQ,
  output logic [PW-1:0]     busRd
);
  logic [W-1:0] fieldQ;

  if (BUS_ACC == ACC_RO && DEV_ACC == ACC_WO) begin : g_live
    assign fieldQ = devIn;
  end else begin : g_store
    logic [PW-1:0] nxt;
    always_comb begin
      nxt = PW'(fieldQ);
      if (BUS_ACC != ACC_RO) begin
        for (int k = 0; k < NW; k++) begin
          if (busWr[k]) nxt[PW-1-k*WORD_W -: WORD_W] = busDat;
        end
      end
      if (DEV_ACC != ACC_RO && devStb) nxt = PW'(devIn);
    end
    always_ff @(posedge clk) begin
      if (!rstN) fieldQ <= '0;
      else       fieldQ <= nxt[W-1:0];
    end
  end

  assign devQ  = (DEV_ACC == ACC_WO) ? '0 : fieldQ;
  assign busRd = (BUS_ACC == ACC_WO) ? '0 : PW'(fieldQ);
endmodule

// File: rtl/csrb_dp.sv
module csrb_dp
  import csrb_pkg::*;
#(
  parameter int RAW_W  = 6,
  parameter int CFG_W  = 16,
  parameter int SHR_W  = 12,
  parameter int LIVE_W = 10,
  parameter int EVT_W  = 8,
  parameter int CMD_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [WORD_W-1:0] busDatW,
  output logic [WORD_W-1:0] busDatR,
  output logic [RAW_W-1:0]  rawVal,
  output logic              rawStb,
  input  logic [RAW_W-1:0]  rawRd,
  output logic [CFG_W-1:0]  cfgQ,
  output logic [SHR_W-1:0]  shrQ,
  input  logic [SHR_W-1:0]  shrIn,
  input  logic              shrStb,
  input  logic [LIVE_W-1:0] liveIn,
  output logic [EVT_W-1:0]  cntQ,
  input  logic [EVT_W-1:0]  cntIn,
  input  logic              cntStb,
  output logic [CMD_W-1:0]  cmdQ
);
  localparam int CFG_N    = wordsFor(CFG_W);
  localparam int SHR_N    = wordsFor(SHR_W);
  localparam int LIVE_N   = wordsFor(LIVE_W);
  localparam int EVT_N    = wordsFor(EVT_W);
  localparam int CMD_N    = wordsFor(CMD_W);
  localparam int RAW_OFF  = 0;
  localparam int CFG_OFF  = 1;
  localparam int SHR_OFF  = CFG_OFF + CFG_N;
  localparam int LIVE_OFF = SHR_OFF + SHR_N;
  localparam int EVT_OFF  = LIVE_OFF + LIVE_N;
  localparam int CMD_OFF  = EVT_OFF + EVT_N;
  localparam int NREG     = CMD_OFF + CMD_N;

  logic [CFG_N*WORD_W-1:0]  cfgRd;
  logic [SHR_N*WORD_W-1:0]  shrRd;
  logic [LIVE_N*WORD_W-1:0] liveRd;
  logic [EVT_N*WORD_W-1:0]  evtRd;
  logic [CMD_N*WORD_W-1:0]  cmdRd;
  logic [LIVE_W-1:0]        liveDevQ;
  logic [WORD_W-1:0]        wordArr [MAX_REGS];
  logic [WORD_W-1:0]        rdNext;

  csrb_field #(.W(CFG_W), .BUS_ACC(ACC_RW), .DEV_ACC(ACC_RO)) u_cfg (
    .clk(clk), .rstN(rstN), .busWr(stb.wrSel[CFG_OFF +: CFG_N]), .busDat(busDatW),
    .devIn('0), .devStb(1'b0), .devQ(cfgQ), .busRd(cfgRd));

  csrb_field #(.W(SHR_W), .BUS_ACC(ACC_RW), .DEV_ACC(ACC_RW)) u_shr (
    .clk(clk), .rstN(rstN), .busWr(stb.wrSel[SHR_OFF +: SHR_N]), .busDat(busDatW),
    .devIn(shrIn), .devStb(shrStb), .devQ(shrQ), .busRd(shrRd));

  csrb_field #(.W(LIVE_W), .BUS_ACC(ACC_RO), .DEV_ACC(ACC_WO)) u_live (
    .clk(clk), .rstN(rstN), .busWr(stb.wrSel[LIVE_OFF +: LIVE_N]), .busDat(busDatW),
    .devIn(liveIn), .devStb(1'b0), .devQ(liveDevQ), .busRd(liveRd));

  csrb_field #(.W(EVT_W), .BUS_ACC(ACC_RO), .DEV_ACC(ACC_RW)) u_evt (
    .clk(clk), .rstN(rstN), .busWr(stb.wrSel[EVT_OFF +: EVT_N]), .busDat(busDatW),
    .devIn(cntIn), .devStb(cntStb), .devQ(cntQ), .busRd(evtRd));

  csrb_field #(.W(CMD_W), .BUS_ACC(ACC_WO), .DEV_ACC(ACC_RO)) u_cmd (
    .clk(clk), .rstN(rstN), .busWr(stb.wrSel[CMD_OFF +: CMD_N]), .busDat(busDatW),
    .devIn('0), .devStb(1'b0), .devQ(cmdQ), .busRd(cmdRd));

  // Word view of the map: word k of a field sits at its base offset + k, MSB first
  always_comb begin
    for (int i = 0; i < MAX_REGS; i++) wordArr[i] = '0;
    wordArr[RAW_OFF] = WORD_W'(rawRd);
    for (int k = 0; k < CFG_N; k++)  wordArr[CFG_OFF+k]  = cfgRd[(CFG_N-k)*WORD_W-1 -: WORD_W];
    for (int k = 0; k < SHR_N; k++)  wordArr[SHR_OFF+k]  = shrRd[(SHR_N-k)*WORD_W-1 -: WORD_W];
    for (int k = 0; k < LIVE_N; k++) wordArr[LIVE_OFF+k] = liveRd[(LIVE_N-k)*WORD_W-1 -: WORD_W];
    for (int k = 0; k < EVT_N; k++)  wordArr[EVT_OFF+k]  = evtRd[(EVT_N-k)*WORD_W-1 -: WORD_W];
    for (int k = 0; k < CMD_N; k++)  wordArr[CMD_OFF+k]  = cmdRd[(CMD_N-k)*WORD_W-1 -: WORD_W];
  end

  always_comb begin
    rdNext = '0;
    for (int i = 0; i < NREG; i++) begin
      if (stb.rdSel[i]) rdNext = rdNext | wordArr[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busDatR <= '0;
      rawVal  <= '0;
      rawStb  <= 1'b0;
    end else begin
      busDatR <= stb.hit ? rdNext : '0;
      rawStb  <= stb.wrSel[RAW_OFF];
      if (stb.wrSel[RAW_OFF]) rawVal <= busDatW[RAW_W-1:0];
    end
  end
endmodule

// File: rtl/csrb_top.sv
module csrb_top
  import csrb_pkg::*;
#(
  parameter int ADR_W    = 14,
  parameter int SEL_W    = 5,
  parameter int BANK_SEL = 3,
  parameter int RAW_W    = 6,
  parameter int CFG_W    = 16,
  parameter int SHR_W    = 12,
  parameter int LIVE_W   = 10,
  parameter int EVT_W    = 8,
  parameter int CMD_W    = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADR_W-1:0]  busAdr,
  input  logic              busWe,
  input  logic [7:0]        busDatW,
  output logic [7:0]        busDatR,
  output logic [RAW_W-1:0]  rawVal,
  output logic              rawStb,
  input  logic [RAW_W-1:0]  rawRd,
  output logic [CFG_W-1:0]  cfgQ,
  output logic [SHR_W-1:0]  shrQ,
  input  logic [SHR_W-1:0]  shrIn,
  input  logic              shrStb,
  input  logic [LIVE_W-1:0] liveIn,
  output logic [EVT_W-1:0]  cntQ,
  input  logic [EVT_W-1:0]  cntIn,
  input  logic              cntStb,
  output logic [CMD_W-1:0]  cmdQ
);
  localparam int NREG = 1 + wordsFor(CFG_W) + wordsFor(SHR_W) + wordsFor(LIVE_W)
                          + wordsFor(EVT_W) + wordsFor(CMD_W);

  strobe_t stb;

  csrb_ctrl #(.ADR_W(ADR_W), .SEL_W(SEL_W), .BANK_SEL(BANK_SEL), .NREG(NREG)) u_ctrl (
    .busAdr(busAdr), .busWe(busWe), .stb(stb));

  csrb_dp #(.RAW_W(RAW_W), .CFG_W(CFG_W), .SHR_W(SHR_W), .LIVE_W(LIVE_W),
            .EVT_W(EVT_W), .CMD_W(CMD_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .busDatW(busDatW), .busDatR(busDatR),
    .rawVal(rawVal), .rawStb(rawStb), .rawRd(rawRd), .cfgQ(cfgQ), .shrQ(shrQ),
    .shrIn(shrIn), .shrStb(shrStb), .liveIn(liveIn), .cntQ(cntQ), .cntIn(cntIn),
    .cntStb(cntStb), .cmdQ(cmdQ));
endmodule

// File: rtl/csrb_chk.sv
module csrb_chk
  import csrb_pkg::*;
#(
  parameter int ADR_W    = 14,
  parameter int SEL_W    = 5,
  parameter int BANK_SEL = 3,
  parameter int RAW_W    = 6,
  parameter int CFG_W    = 16,
  parameter int SHR_W    = 12,
  parameter int LIVE_W   = 10,
  parameter int EVT_W    = 8,
  parameter int CMD_W    = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADR_W-1:0]  busAdr,
  input logic              busWe,
  input logic [7:0]        busDatW,
  input logic [7:0]        busDatR,
  input logic [RAW_W-1:0]  rawVal,
  input logic              rawStb,
  input logic [CFG_W-1:0]  cfgQ,
  input logic [SHR_W-1:0]  shrQ,
  input logic [SHR_W-1:0]  shrIn,
  input logic              shrStb,
  input logic [LIVE_W-1:0] liveIn,
  input logic [EVT_W-1:0]  cntQ,
  input logic              cntStb
);
  localparam int OFF_W    = ADR_W - SEL_W;
  localparam int LIVE_OFF = 1 + wordsFor(CFG_W) + wordsFor(SHR_W);
  localparam int LIVE_LO  = LIVE_OFF + wordsFor(LIVE_W) - 1;
  localparam int CMD_OFF  = LIVE_OFF + wordsFor(LIVE_W) + wordsFor(EVT_W);
  localparam int NREG     = CMD_OFF + wordsFor(CMD_W);

  logic bankOk;
  int   offs;
  assign bankOk = (busAdr[ADR_W-1 -: SEL_W] == SEL_W'(BANK_SEL));
  assign offs   = int'(busAdr[OFF_W-1:0]);

  AST_OTHER_BANK_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !bankOk |=> busDatR == '0); // R1
  AST_RAW_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    (bankOk && busWe && offs == 0) |=> (rawStb && rawVal == $past(busDatW[RAW_W-1:0]))); // R3
  AST_RAW_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !(bankOk && busWe && offs == 0) |=> !rawStb); // R3
  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !busWe |=> $stable(cfgQ)); // R5
  AST_SHR_DEV_WINS: assert property (@(posedge clk) disable iff (!rstN)
    shrStb |=> shrQ == $past(shrIn)); // R6
  AST_LIVE_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (bankOk && offs == LIVE_LO) |=> busDatR == 8'($past(liveIn))); // R7
  AST_EVT_BUS_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    !cntStb |=> $stable(cntQ)); // R8
  AST_CMD_NO_READ: assert property (@(posedge clk) disable iff (!rstN)
    (bankOk && offs >= CMD_OFF && offs < NREG) |=> busDatR == '0); // R9
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (bankOk && offs >= NREG) |=> busDatR == '0); // R10
endmodule

bind csrb_top csrb_chk #(
  .ADR_W(ADR_W), .SEL_W(SEL_W), .BANK_SEL(BANK_SEL), .RAW_W(RAW_W), .CFG_W(CFG_W),
  .SHR_W(SHR_W), .LIVE_W(LIVE_W), .EVT_W(EVT_W), .CMD_W(CMD_W)
) u_chk (
  .clk(clk), .rstN(rstN), .busAdr(busAdr), .busWe(busWe), .busDatW(busDatW),
  .busDatR(busDatR), .rawVal(rawVal), .rawStb(rawStb), .cfgQ(cfgQ), .shrQ(shrQ),
  .shrIn(shrIn), .shrStb(shrStb), .liveIn(liveIn), .cntQ(cntQ), .cntStb(cntStb));

// File: tb/sim_csrb_top.sv
module sim_csrb_top;
  logic        clk = 1'b0;
  logic        rstN;
  logic [13:0] busAdr;
  logic        busWe;
  logic [7:0]  busDatW;
  logic [7:0]  busDatR;
  logic [5:0]  rawVal;
  logic        rawStb;
  logic [5:0]  rawRd;
  logic [15:0] cfgQ;
  logic [11:0] shrQ;
  logic [11:0] shrIn;
  logic        shrStb;
  logic [9:0]  liveIn;
  logic [7:0]  cntQ;
  logic [7:0]  cntIn;
  logic        cntStb;
  logic [7:0]  cmdQ;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 0;

  // Bench model of the register state
  logic [5:0]  mRaw;
  logic        mStb;
  logic [15:0] mCfg;
  logic [11:0] mShr;
  logic [7:0]  mEvt;
  logic [7:0]  mCmd;

  always #2.5 clk = ~clk;

  csrb_top u0 (
    .clk(clk), .rstN(rstN), .busAdr(busAdr), .busWe(busWe), .busDatW(busDatW),
    .busDatR(busDatR), .rawVal(rawVal), .rawStb(rawStb), .rawRd(rawRd), .cfgQ(cfgQ),
    .shrQ(shrQ), .shrIn(shrIn), .shrStb(shrStb), .liveIn(liveIn), .cntQ(cntQ),
    .cntIn(cntIn), .cntStb(cntStb), .cmdQ(cmdQ));

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [13:0] adrOf(input int bank, input int off);
    return {5'(bank), 9'(off)};
  endfunction

  function automatic logic [7:0] expRead(input logic [13:0] a, input logic [9:0] lv,
                                         input logic [5:0] rr);
    if (a[13:9] != 5'd3) return 8'h00;
    case (int'(a[8:0]))
      0: return {2'b00, rr};
      1: return mCfg[15:8];
      2: return mCfg[7:0];
      3: return {4'h0, mShr[11:8]};
      4: return mShr[7:0];
      5: return {6'h00, lv[9:8]};
      6: return lv[7:0];
      7: return mEvt;
      default: return 8'h00;  // offset 8 write-only, 9+ unmapped
    endcase
  endfunction

  // One bus cycle: drive at negedge, compare everything at the next negedge
  task automatic step(input logic [13:0] a, input logic w, input logic [7:0] d,
                      input logic sStb, input logic [11:0] sIn,
                      input logic cStb, input logic [7:0] cIn,
                      input logic [9:0] lv, input logic [5:0] rr, input string tag);
    logic [7:0] eRd;
    busAdr = a; busWe = w; busDatW = d; shrStb = sStb; shrIn = sIn;
    cntStb = cStb; cntIn = cIn; liveIn = lv; rawRd = rr;
    eRd  = expRead(a, lv, rr);
    mStb = 1'b0;
    if (w && a[13:9] == 5'd3) begin
      case (int'(a[8:0]))
        0: begin mRaw = d[5:0]; mStb = 1'b1; end
        1: mCfg[15:8] = d;
        2: mCfg[7:0]  = d;
        3: mShr[11:8] = d[3:0];
        4: mShr[7:0]  = d;
        8: mCmd = d;
        default: ;
      endcase
    end
    if (sStb) mShr = sIn;
    if (cStb) mEvt = cIn;
    @(negedge clk);
    chk(tag, 32'(busDatR), 32'(eRd));
    chk("R3 rawStb", 32'(rawStb), 32'(mStb));
    chk("R3 rawVal", 32'(rawVal), 32'(mRaw));
    chk("R5 cfgQ", 32'(cfgQ), 32'(mCfg));
    chk("R6 shrQ", 32'(shrQ), 32'(mShr));
    chk("R8 cntQ", 32'(cntQ), 32'(mEvt));
    chk("R9 cmdQ", 32'(cmdQ), 32'(mCmd));
  endtask

  task automatic rd(input int bank, input int off, input logic [9:0] lv,
                    input logic [5:0] rr, input string tag);
    step(adrOf(bank, off), 1'b0, 8'h00, 1'b0, 12'h000, 1'b0, 8'h00, lv, rr, tag);
  endtask

  task automatic wr(input int bank, input int off, input logic [7:0] d, input string tag);
    step(adrOf(bank, off), 1'b1, d, 1'b0, 12'h000, 1'b0, 8'h00, 10'h000, 6'h00, tag);
  endtask

  initial begin
    #200000;
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rstN = 1'b0; busAdr = '0; busWe = 0; busDatW = '0; rawRd = '0;
    shrIn = '0; shrStb = 0; liveIn = '0; cntIn = '0; cntStb = 0;
    mRaw = '0; mStb = 0; mCfg = '0; mShr = '0; mEvt = '0; mCmd = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R11: reset state
    chk("R11 busDatR", 32'(busDatR), 0);
    chk("R11 rawStb", 32'(rawStb), 0);
    chk("R11 rawVal", 32'(rawVal), 0);
    chk("R11 cfgQ", 32'(cfgQ), 0);
    chk("R11 shrQ", 32'(shrQ), 0);
    chk("R11 cntQ", 32'(cntQ), 0);
    chk("R11 cmdQ", 32'(cmdQ), 0);

    // R3 raw register write and read
    wr(3, 0, 8'hFF, "R3 wr");
    rd(3, 0, 10'h000, 6'h2A, "R3 read rawRd");
    // R4/R5 MSB-first slicing of the configuration field
    wr(3, 1, 8'hA5, "R5 wr hi");
    wr(3, 2, 8'h3C, "R5 wr lo");
    rd(3, 1, 10'h000, 6'h00, "R4 cfg hi");
    rd(3, 2, 10'h000, 6'h00, "R4 cfg lo");
    wr(3, 4, 8'h77, "R4 shr lo wr");
    wr(3, 3, 8'hFE, "R4 shr hi wr");
    rd(3, 3, 10'h000, 6'h00, "R4 shr hi");
    rd(3, 4, 10'h000, 6'h00, "R4 shr lo");
    // R6 collision: bus write and core strobe in the same cycle
    step(adrOf(3, 3), 1'b1, 8'hFF, 1'b1, 12'h123, 1'b0, 8'h00, 10'h000, 6'h00, "R6 collide hi");
    step(adrOf(3, 4), 1'b1, 8'h00, 1'b1, 12'h9BC, 1'b0, 8'h00, 10'h000, 6'h00, "R6 collide lo");
    rd(3, 4, 10'h000, 6'h00, "R6 read back");
    // R7 live field
    rd(3, 5, 10'h2D7, 6'h00, "R7 live hi");
    rd(3, 6, 10'h2D7, 6'h00, "R7 live lo");
    wr(3, 6, 8'h11, "R7 wr ignored");
    rd(3, 6, 10'h155, 6'h00, "R7 live after wr");
    // R8 event field
    step(adrOf(3, 7), 1'b0, 8'h00, 1'b0, 12'h000, 1'b1, 8'h5E, 10'h000, 6'h00, "R8 dev load");
    wr(3, 7, 8'h81, "R8 bus wr ignored");
    rd(3, 7, 10'h000, 6'h00, "R8 read evt");
    // R9 command field
    wr(3, 8, 8'h9A, "R9 wr");
    rd(3, 8, 10'h000, 6'h00, "R9 read zero");
    // R10 unmapped
    wr(3, 9, 8'hEE, "R10 wr 9");
    rd(3, 9, 10'h000, 6'h00, "R10 read 9");
    wr(3, 300, 8'hEE, "R10 wr 300");
    rd(3, 300, 10'h000, 6'h00, "R10 read 300");
    // R1 other bank
    wr(4, 1, 8'h00, "R1 wr other bank");
    wr(4, 0, 8'h12, "R1 raw other bank");
    rd(4, 0, 10'h3FF, 6'h3F, "R1 read other bank");
    rd(3, 1, 10'h000, 6'h00, "R1 cfg kept");

    // R2 random mix: every read checked against the model
    for (int i = 0; i < 600; i++) begin
      int bank;
      bank = ($urandom_range(0, 7) == 0) ? 4 : 3;
      step(adrOf(bank, $urandom_range(0, 11)), 1'($urandom_range(0, 1)), 8'($urandom),
           ($urandom_range(0, 3) == 0), 12'($urandom), ($urandom_range(0, 3) == 0),
           8'($urandom), 10'($urandom), 6'($urandom), "R2 random read");
    end

    done = 1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule